// File: doc/BRIEF.md
# Multiplexed Burst Bus Master Sequencer

This block is the bus-cycle state machine of a 32-bit external bus master whose address and data share one set of lines. A request interface with a valid/ready handshake hands it a start address, a direction, a word count of one to four and up to four write words. The block then runs the shared lines through a single address cycle, one wait/data phase per word and a recovery phase.

The target paces the access with one active-low ready/recover input, `rdy_n`. While the bus is in wait/data, a low `rdy_n` completes the current word. While the bus is in recovery, a low `rdy_n` keeps the bus there. An external hold request parks the bus with the lines released. When a new request is waiting at the end of recovery, the block starts it at once and does not pass through idle.

The states are IDLE, ADDR, DATA, REC and HOLD. The transitions are:
- IDLE→ADDR when a legal request is accepted.
- IDLE→HOLD when `hold_req` is high.
- ADDR→DATA always.
- DATA→DATA on a wait cycle or on a completed word that is not the last.
- DATA→REC when the last word completes.
- REC→REC while `rdy_n` is low.
- REC→ADDR, REC→HOLD or REC→IDLE once `rdy_n` is high, chosen in that order of priority as HOLD, then ADDR, then IDLE.
- HOLD→IDLE when `hold_req` drops.

Top module: `mbus_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the bus is IDLE. In IDLE, `ad_oe`=0, `addr_phase`=0, `hold_ack`=0, `last_n`=1, `rd_valid`=0, and `req_ready`=1 whenever `hold_req` is 0, whatever the value of `rdy_n`.
- R2: `req_ready` is 1 only in IDLE, or in REC in a cycle where `rdy_n` is high, and only when `hold_req` is low. A request with `req_valid`=1 and `req_ready`=1 that does not cross a boundary is accepted. In the next cycle, `addr_phase`=1, `ad_oe`=1, `ad_out`=`req_addr` and `bus_write`=`req_write`.
- R3: The address phase lasts exactly one cycle and is followed by DATA, whatever the value of `rdy_n`.
- R4: A data word completes only in a DATA cycle where `rdy_n` is sampled low. Any number of wait cycles with `rdy_n` high may come first, and during them the word index does not change.
- R5: `req_len` holds the word count minus one (0 means 1 word, 3 means 4 words). After each completed word that is not the last, the bus stays in DATA for the next word.
- R6: `last_n` is 0 in every DATA cycle of the final word, including the only word of a single-word access, and is 1 in every other cycle.
- R7: After the final word, the bus is in REC with `ad_oe`=0. It stays in REC while `rdy_n` is low and leaves in the first REC cycle where `rdy_n` is high.
- R8: On leaving REC, a legal request presented in that cycle goes straight to ADDR in the next cycle. With no request, the bus goes to IDLE.
- R9: In a read DATA cycle, `ad_oe`=0. On each completing read word, `rd_valid` is 1 for that cycle only and `rd_data` equals `ad_in`.
- R10: In a write DATA cycle for word k, `ad_oe`=1 and `ad_out` equals bits [32k+31:32k] of the `req_wdata` that was captured at acceptance.
- R11: `beat_addr` equals the start address plus 4·k during word k.
- R12: A request is rejected when `req_addr[3:2]` + `req_len` > 3, meaning it would cross a 16-byte aligned boundary. On rejection, `req_err`=1 in the acceptance cycle, the request is consumed, and no address phase follows.
- R13: When `hold_req` is high in IDLE or at the exit of REC, the request is not taken (`req_ready`=0) and HOLD follows. In HOLD, `hold_ack`=1 and `ad_oe`=0. The cycle after `hold_req` is sampled low, the bus is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | 32 | Start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Word count minus one |
| req_wdata | input | 128 | Write words, word k in bits [32k+31:32k] |
| req_err | output | 1 | Request rejected (boundary crossing) |
| ad_out | output | 32 | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 32 | Shared lines, sampled value |
| addr_phase | output | 1 | Address cycle strobe |
| bus_write | output | 1 | Direction of current access |
| last_n | output | 1 | Active-low final-word indicator |
| rdy_n | input | 1 | Active-low ready/recover from target |
| beat_addr | output | 32 | Address of current word |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word strobe |
| hold_req | input | 1 | External hold request |
| hold_ack | output | 1 | Hold acknowledge |

## Verification
The exit from recovery is the cycle where the most functions coincide. In that one cycle, the recovery release by `rdy_n`, the acceptance of a back-to-back request, a boundary rejection and a hold request can all be decided together. The bench provokes this cycle by chaining accesses, both randomly and in directed cases that hold a request ready while `rdy_n` rises. In some of those cases `hold_req` is raised in the same cycle, or the waiting request is one that must be rejected. Each case is judged by `req_ready` and `req_err` in that cycle and by `addr_phase` or `hold_ack` in the next cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_REC  = 3'd3,
        ST_HOLD = 3'd4
    } bus_state_e;
endpackage

// File: rtl/mbus_req_check.sv
// Flags a burst whose last word would fall past the aligned burst window.
module mbus_req_check #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 2,
    parameter int BYTE_SH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              crosses
);
    logic [LEN_W:0] end_idx;

    always_comb begin
        end_idx = {1'b0, addr[BYTE_SH +: LEN_W]} + {1'b0, len};
        crosses = end_idx[LEN_W];
    end
endmodule

// File: rtl/mbus_xfer_regs.sv
// Captures the accepted request and steps the word index and address.
module mbus_xfer_regs #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 4,
    localparam int LEN_W    = $clog2(MAX_BEATS),
    localparam int STEP     = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        adv,
    input  logic [ADDR_W-1:0]           ld_addr,
    input  logic                        ld_write,
    input  logic [LEN_W-1:0]            ld_len,
    input  logic [MAX_BEATS*DATA_W-1:0] ld_wdata,
    output logic [ADDR_W-1:0]           cur_addr,
    output logic [DATA_W-1:0]           cur_word,
    output logic                        is_last,
    output logic                        xfer_write
);
    logic [DATA_W-1:0] words_q [MAX_BEATS];
    logic [LEN_W-1:0]  beat_q;
    logic [LEN_W-1:0]  len_q;

    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words_q[g] <= '0;
            else if (load)
                words_q[g] <= ld_wdata[g*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q     <= '0;
            len_q      <= '0;
            cur_addr   <= '0;
            xfer_write <= 1'b0;
        end else if (load) begin
            beat_q     <= '0;
            len_q      <= ld_len;
            cur_addr   <= ld_addr;
            xfer_write <= ld_write;
        end else if (adv && !is_last) begin
            beat_q   <= beat_q + 1'b1;
            cur_addr <= cur_addr + ADDR_W'(STEP);
        end
    end

    assign cur_word = words_q[beat_q];
    assign is_last  = (beat_q == len_q);
endmodule

// File: rtl/mbus_fsm.sv
// Bus-cycle state register, next-state logic and request handshake.
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_bad,
    input  logic       hold_req,
    input  logic       rdy_n,
    input  logic       is_last,
    output bus_state_e state,
    output logic       req_ready,
    output logic       accept,
    output logic       reject,
    output logic       beat_done
);
    bus_state_e state_nx;
    logic       window;

    always_comb begin
        window    = (state == ST_IDLE) || (state == ST_REC && rdy_n);
        req_ready = window && !hold_req;
        accept    = req_ready && req_valid && !req_bad;
        reject    = req_ready && req_valid && req_bad;
        beat_done = (state == ST_DATA) && !rdy_n;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hold_req)    state_nx = ST_HOLD;
                else if (accept) state_nx = ST_ADDR;
            end
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA: begin
                if (beat_done && is_last) state_nx = ST_REC;
            end
            ST_REC: begin
                if (rdy_n) begin
                    if (hold_req)    state_nx = ST_HOLD;
                    else if (accept) state_nx = ST_ADDR;
                    else             state_nx = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!hold_req) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/mbus_seq.sv
// Top: multiplexed address/data burst sequencer.
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 4,
    localparam int LEN_W    = $clog2(MAX_BEATS),
    localparam int BYTE_SH  = $clog2(DATA_W / 8)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic [LEN_W-1:0]            req_len,
    input  logic [MAX_BEATS*DATA_W-1:0] req_wdata,
    output logic                        req_err,
    output logic [DATA_W-1:0]           ad_out,
    output logic                        ad_oe,
    input  logic [DATA_W-1:0]           ad_in,
    output logic                        addr_phase,
    output logic                        bus_write,
    output logic                        last_n,
    input  logic                        rdy_n,
    output logic [ADDR_W-1:0]           beat_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_valid,
    input  logic                        hold_req,
    output logic                        hold_ack
);
    bus_state_e        state;
    logic              req_bad;
    logic              accept;
    logic              beat_done;
    logic              is_last;
    logic              xfer_write;
    logic [DATA_W-1:0] cur_word;

    mbus_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_SH(BYTE_SH)) u_check (
        .addr    (req_addr),
        .len     (req_len),
        .crosses (req_bad)
    );

    mbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bad   (req_bad),
        .hold_req  (hold_req),
        .rdy_n     (rdy_n),
        .is_last   (is_last),
        .state     (state),
        .req_ready (req_ready),
        .accept    (accept),
        .reject    (req_err),
        .beat_done (beat_done)
    );

    mbus_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .adv        (beat_done),
        .ld_addr    (req_addr),
        .ld_write   (req_write),
        .ld_len     (req_len),
        .ld_wdata   (req_wdata),
        .cur_addr   (beat_addr),
        .cur_word   (cur_word),
        .is_last    (is_last),
        .xfer_write (xfer_write)
    );

    // Output decode per state.
    always_comb begin
        ad_out     = '0;
        ad_oe      = 1'b0;
        addr_phase = 1'b0;
        bus_write  = 1'b0;
        last_n     = 1'b1;
        rd_data    = '0;
        rd_valid   = 1'b0;
        hold_ack   = 1'b0;
        unique case (state)
            ST_IDLE, ST_REC: ;
            ST_ADDR: begin
                ad_out     = DATA_W'(beat_addr);
                ad_oe      = 1'b1;
                addr_phase = 1'b1;
                bus_write  = xfer_write;
            end
            ST_DATA: begin
                bus_write = xfer_write;
                last_n    = !is_last;
                if (xfer_write) begin
                    ad_out = cur_word;
                    ad_oe  = 1'b1;
                end else if (beat_done) begin
                    rd_data  = ad_in;
                    rd_valid = 1'b1;
                end
            end
            ST_HOLD: hold_ack = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_e        state,
    input logic              rdy_n,
    input logic              ad_oe,
    input logic              addr_phase,
    input logic              bus_write,
    input logic              last_n,
    input logic              rd_valid,
    input logic              req_err,
    input logic              req_ready,
    input logic              hold_ack,
    input logic [ADDR_W-1:0] beat_addr
);
    p_addr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> (state == ST_DATA && !addr_phase));

    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && rdy_n) |=> (state == ST_DATA && $stable(beat_addr) && $stable(last_n)));

    p_last_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !last_n |-> state == ST_DATA);

    p_rec_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC && !rdy_n) |=> (state == ST_REC && !ad_oe));

    p_read_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !bus_write) |-> !ad_oe);

    p_read_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!rdy_n && !bus_write));

    p_reject_no_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !addr_phase);

    p_hold_float_r13: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ad_oe && !req_ready && last_n));
endmodule

bind mbus_seq mbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .rdy_n      (rdy_n),
    .ad_oe      (ad_oe),
    .addr_phase (addr_phase),
    .bus_write  (bus_write),
    .last_n     (last_n),
    .rd_valid   (rd_valid),
    .req_err    (req_err),
    .req_ready  (req_ready),
    .hold_ack   (hold_ack),
    .beat_addr  (beat_addr)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic [1:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         req_err;
    logic [31:0]  ad_out;
    logic         ad_oe;
    logic [31:0]  ad_in = '0;
    logic         addr_phase;
    logic         bus_write;
    logic         last_n;
    logic         rdy_n = 1'b1;
    logic [31:0]  beat_addr;
    logic [31:0]  rd_data;
    logic         rd_valid;
    logic         hold_req = 1'b0;
    logic         hold_ack;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mbus_seq u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit crosses(input logic [31:0] a, input logic [1:0] len);
        return (32'(a[3:2]) + 32'(len)) > 32'd3;
    endfunction

    function automatic logic [31:0] word_k(input logic [127:0] w, input int k);
        return w[k*32 +: 32];
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Entered just after a negedge with the bus in IDLE or at REC exit.
    // Returns at the REC-exit cycle with rdy_n driven high.
    task automatic do_access(input logic [31:0] a, input bit wr, input logic [1:0] len,
                             input logic [127:0] wd, input int max_wait, input int max_rec);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_len = len; req_wdata = wd;
        #1;
        chk(req_ready == 1'b1, "R2 ready", 32'(req_ready), 32'd1);
        chk(req_err == 1'b0, "R12 no error on legal request", 32'(req_err), 32'd0);
        next_cycle();
        req_valid = 1'b0; req_wdata = rnd128(); rdy_n = 1'($urandom());
        #1;
        chk(addr_phase && ad_oe && ad_out == a, "R2 address phase", ad_out, a);
        chk(bus_write == wr, "R2 direction", 32'(bus_write), 32'(wr));
        chk(last_n == 1'b1, "R6 last_n high in address", 32'(last_n), 32'd1);
        for (int k = 0; k <= int'(len); k++) begin
            int w = $urandom_range(max_wait, 0);
            for (int c = 0; c <= w; c++) begin
                logic [31:0] din = $urandom();
                next_cycle();
                rdy_n = (c != w); ad_in = din;
                #1;
                chk(!addr_phase, "R3 single address cycle", 32'(addr_phase), 32'd0);
                chk(last_n == (k != int'(len)), "R6 last_n in data", 32'(last_n), 32'(k != int'(len)));
                chk(beat_addr == a + 32'(4 * k), "R11 word address", beat_addr, a + 32'(4 * k));
                if (wr) begin
                    chk(ad_oe && ad_out == word_k(wd, k), "R10 write word", ad_out, word_k(wd, k));
                end else begin
                    chk(!ad_oe, "R9 lines released on read", 32'(ad_oe), 32'd0);
                    chk(rd_valid == (c == w), "R4 read strobe only on ready", 32'(rd_valid), 32'(c == w));
                    if (c == w) chk(rd_data == din, "R9 read data", rd_data, din);
                end
            end
        end
        begin
            int r = $urandom_range(max_rec, 0);
            for (int c = 0; c <= r; c++) begin
                next_cycle();
                rdy_n = (c == r);
                #1;
                chk(!ad_oe && last_n && !addr_phase, "R7 recovery lines released", 32'(ad_oe), 32'd0);
                chk(req_ready == (c == r), "R7 recovery held by rdy_n", 32'(req_ready), 32'(c == r));
            end
        end
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        next_cycle();
        rdy_n = 1'b0;
        #1;
        chk(req_ready && !addr_phase && !hold_ack, "R8 idle after recovery", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        #1;
        chk(!ad_oe && !addr_phase && !hold_ack && last_n && !rd_valid, "R1 reset outputs", 32'(ad_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rdy_n = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1 idle ready", 32'(req_ready), 32'd1);

        // Directed: single read, single write, 4-word write, back-to-back read.
        do_access(32'h1000_0000, 1'b0, 2'd0, '0, 0, 0);
        go_idle();
        do_access(32'h2000_0004, 1'b1, 2'd0, rnd128(), 3, 2);
        do_access(32'h3000_0010, 1'b1, 2'd3, rnd128(), 2, 2);   // R5 four words, R8 chained
        do_access(32'h3000_0028, 1'b0, 2'd1, '0, 3, 0);
        go_idle();

        // R12: crossing request from IDLE.
        req_valid = 1'b1; req_addr = 32'h4000_0008; req_len = 2'd2; req_write = 1'b0;
        #1;
        chk(req_ready && req_err, "R12 reject flagged", 32'(req_err), 32'd1);
        next_cycle();
        req_valid = 1'b0;
        #1;
        chk(!addr_phase && req_ready, "R12 no address phase after reject", 32'(addr_phase), 32'd0);

        // R12 at recovery exit: rejected request, bus returns to IDLE.
        do_access(32'h4000_0000, 1'b0, 2'd1, '0, 1, 1);
        req_valid = 1'b1; req_addr = 32'h4000_000C; req_len = 2'd1;
        #1;
        chk(req_err == 1'b1, "R12 reject at recovery exit", 32'(req_err), 32'd1);
        next_cycle();
        req_valid = 1'b0; rdy_n = 1'b0;
        #1;
        chk(!addr_phase && req_ready, "R12 idle after reject", 32'(addr_phase), 32'd0);

        // R13: hold from IDLE beats a pending request.
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 32'h5000_0000; req_len = 2'd0;
        #1;
        chk(req_ready == 1'b0, "R13 request blocked by hold", 32'(req_ready), 32'd0);
        next_cycle();
        #1;
        chk(hold_ack && !ad_oe, "R13 hold entered", 32'(hold_ack), 32'd1);
        next_cycle();
        hold_req = 1'b0;
        #1;
        chk(hold_ack == 1'b1, "R13 hold while request sampled", 32'(hold_ack), 32'd1);
        next_cycle();
        req_valid = 1'b0;
        #1;
        chk(!hold_ack && req_ready && !addr_phase, "R13 idle after hold", 32'(hold_ack), 32'd0);

        // R13 at recovery exit with a request also waiting.
        do_access(32'h6000_0000, 1'b1, 2'd1, rnd128(), 1, 2);
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 32'h6000_0010; req_len = 2'd0;
        #1;
        chk(req_ready == 1'b0, "R13 hold wins at recovery exit", 32'(req_ready), 32'd0);
        next_cycle();
        req_valid = 1'b0;
        #1;
        chk(hold_ack && !addr_phase, "R13 hold after recovery", 32'(hold_ack), 32'd1);
        hold_req = 1'b0;
        next_cycle();
        #1;
        chk(!hold_ack && req_ready, "R13 hold released", 32'(hold_ack), 32'd0);

        // Constrained random accesses, chained or separated.
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a = {$urandom()} & 32'hFFFF_FFFC;
            logic [1:0]  ln = 2'($urandom_range(32'(3 - int'(a[3:2])), 0));
            if (crosses(a, ln)) ln = 2'd0;
            do_access(a, 1'($urandom()), ln, rnd128(), 4, 3);
            if ($urandom_range(2, 0) == 0) go_idle();
        end
        go_idle();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule